// File: doc/BRIEF.md
# Saturating Vector Halfword Adder

This execution unit takes one 32-bit instruction word together with two 128-bit vector operands. It splits each operand into eight unsigned 16-bit lanes and adds them lane by lane. The extended opcode in the instruction word picks the variant. The saturating variant clips every lane sum at 0xFFFF. The modulo variant lets every lane sum wrap. The unit registers the 128-bit result, the destination register index and a flag that marks a word it does not recognise. The result appears one clock after issue.

A one-bit sticky status flag records that a saturating add has clipped at least one lane since software last wrote the flag. Arithmetic can only set it. A status write port, sampled on the same clock edge as an issued instruction, is the only way to load a new value into the flag. The current value of the flag is always visible on an output.

Top module: `vhadd_unit`

## Requirements
- R1: The instruction is decoded with bit 0 as its most significant bit. A word is accepted only when bits 0-5 (instr[31:26]) equal 4 and bits 21-31 (instr[10:0]) equal 576 (saturating add) or 64 (modulo add). The destination index in bits 6-10 (instr[25:21]) is returned on res_dst. All-zero register fields with the saturating opcode give the word 0x10000240.
- R2: Each operand holds eight 16-bit lanes. Lane 0 is bits [127:112] and lane 7 is bits [15:0]. Result lane i depends only on lane i of each operand.
- R3: For the saturating add, each result lane equals min(A lane + B lane, 0xFFFF). A sum of exactly 0xFFFF is not a clamp.
- R4: For the modulo add, each result lane equals (A lane + B lane) mod 65536.
- R5: An executed saturating add in which any lane clamps sets stat_sat after the same clock edge.
- R6: Arithmetic never clears stat_sat. Once set, it stays set until a status write with stat_wr_sat=0.
- R7: A modulo add never changes stat_sat.
- R8: A word with any other primary or extended opcode gives unhandled=1 and res_valid=0 for one cycle and leaves stat_sat unchanged.
- R9: When a status write and a saturating add occur on the same edge, stat_sat becomes stat_wr_sat OR (any lane clamped).
- R10: res_valid, res_data, res_dst and unhandled are registered one cycle after issue_valid. In a cycle with no issue, res_valid and unhandled are 0.
- R11: After synchronous reset, res_valid, unhandled, res_data, res_dst and stat_sat are all 0.
- R12: The saturating add gives res_valid=1 with its result even when no lane clamps.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 128 | Source A vector |
| opnd_b | input | 128 | Source B vector |
| stat_wr_en | input | 1 | Write the sticky flag this cycle |
| stat_wr_sat | input | 1 | Value to write into the sticky flag |
| res_valid | output | 1 | Registered result is valid |
| res_data | output | 128 | Registered vector result |
| res_dst | output | 5 | Registered destination register index |
| unhandled | output | 1 | Registered flag for an unrecognised word |
| stat_sat | output | 1 | Current sticky saturation flag |

## Verification
The hardest situation to create from the ports is a status write and a clamping saturating add on the same edge. The write must be overridden by the clamp in one case and must take effect alone in the other. The bench issues both in one cycle twice: once with an operand pair that clamps a lane and once with a pair that does not. Stickiness is checked by a non-clamping add that follows a clamping one. The boundary between a clamp and no clamp is checked with a lane sum of exactly 0xFFFF and with 0xFFFF plus one.

// File: rtl/vhadd_pkg.sv
package vhadd_pkg;
    parameter int INSTR_W   = 32;
    parameter int LANE_W    = 16;
    parameter int LANES     = 8;
    parameter int VEC_W     = LANE_W * LANES;
    parameter int REG_W     = 5;
    parameter int PRIM_W    = 6;
    parameter int XO_W      = 11;

    parameter logic [PRIM_W-1:0] PRIM_VEC = 6'd4;
    parameter logic [XO_W-1:0]   XO_SAT   = 11'd576;
    parameter logic [XO_W-1:0]   XO_MOD   = 11'd64;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_ADD_SAT = 2'd1,
        OP_ADD_MOD = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
    } dec_t;

    function automatic logic [PRIM_W-1:0] prim_of(input logic [INSTR_W-1:0] w);
        return w[INSTR_W-1 -: PRIM_W];
    endfunction

    function automatic logic [XO_W-1:0] xo_of(input logic [INSTR_W-1:0] w);
        return w[XO_W-1:0];
    endfunction
endpackage

// File: rtl/vhadd_decode.sv
module vhadd_decode
    import vhadd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int DST_HI = INSTR_W - PRIM_W - 1;
    localparam int SA_HI  = DST_HI - REG_W;
    localparam int SB_HI  = SA_HI - REG_W;

    always_comb begin
        dec.dst   = instr[DST_HI -: REG_W];
        dec.src_a = instr[SA_HI -: REG_W];
        dec.src_b = instr[SB_HI -: REG_W];
        dec.kind  = OP_NONE;
        if (prim_of(instr) == PRIM_VEC) begin
            if (xo_of(instr) == XO_SAT)
                dec.kind = OP_ADD_SAT;
            else if (xo_of(instr) == XO_MOD)
                dec.kind = OP_ADD_MOD;
        end
    end
endmodule

// File: rtl/vhadd_lanes.sv
module vhadd_lanes
    import vhadd_pkg::*;
(
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             sat_mode,
    output logic [VEC_W-1:0] sum,
    output logic [LANES-1:0] clamp
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HI = VEC_W - 1 - i * LANE_W;
        logic [LANE_W:0] wide;
        always_comb begin
            wide     = {1'b0, a[HI -: LANE_W]} + {1'b0, b[HI -: LANE_W]};
            clamp[i] = wide[LANE_W];
            if (sat_mode && wide[LANE_W])
                sum[HI -: LANE_W] = {LANE_W{1'b1}};
            else
                sum[HI -: LANE_W] = wide[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/vhadd_status.sv
module vhadd_status (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    input  logic clip_evt,
    output logic sat_q
);
    logic base;

    always_comb base = wr_en ? wr_val : sat_q;

    always_ff @(posedge clk) begin
        if (rst) sat_q <= 1'b0;
        else     sat_q <= base | clip_evt;
    end
endmodule

// File: rtl/vhadd_unit.sv
module vhadd_unit
    import vhadd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [VEC_W-1:0]   opnd_a,
    input  logic [VEC_W-1:0]   opnd_b,
    input  logic               stat_wr_en,
    input  logic               stat_wr_sat,
    output logic               res_valid,
    output logic [VEC_W-1:0]   res_data,
    output logic [REG_W-1:0]   res_dst,
    output logic               unhandled,
    output logic               stat_sat
);
    dec_t             dec;
    logic [VEC_W-1:0] lane_sum;
    logic [LANES-1:0] lane_clamp;
    logic             is_sat;
    logic             legal;
    logic             clip_evt;

    vhadd_decode u_dec (.instr(instr), .dec(dec));

    always_comb begin
        is_sat   = (dec.kind == OP_ADD_SAT);
        legal    = (dec.kind != OP_NONE);
        clip_evt = issue_valid && is_sat && (|lane_clamp);
    end

    vhadd_lanes u_lanes (
        .a(opnd_a), .b(opnd_b), .sat_mode(is_sat),
        .sum(lane_sum), .clamp(lane_clamp)
    );

    vhadd_status u_stat (
        .clk(clk), .rst(rst), .wr_en(stat_wr_en), .wr_val(stat_wr_sat),
        .clip_evt(clip_evt), .sat_q(stat_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            unhandled <= 1'b0;
            res_data  <= '0;
            res_dst   <= '0;
        end else begin
            res_valid <= issue_valid && legal;
            unhandled <= issue_valid && !legal;
            if (issue_valid && legal) begin
                res_data <= lane_sum;
                res_dst  <= dec.dst;
            end
        end
    end
endmodule

// File: rtl/vhadd_chk.sv
module vhadd_chk
    import vhadd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               issue_valid,
    input logic [INSTR_W-1:0] instr,
    input logic               stat_wr_en,
    input logic               stat_wr_sat,
    input logic               res_valid,
    input logic               unhandled,
    input logic               stat_sat
);
    logic prim_ok, is_mod_w, is_sat_w;
    always_comb begin
        prim_ok  = instr[31:26] == 6'd4;
        is_mod_w = prim_ok && instr[10:0] == 11'd64;
        is_sat_w = prim_ok && instr[10:0] == 11'd576;
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> (!res_valid && !unhandled));

    // R8
    exclusive_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && unhandled));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_sat && !stat_wr_en) |=> stat_sat);

    // R7
    mod_no_touch_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && is_mod_w && !stat_wr_en) |=> $stable(stat_sat));

    // R8
    unknown_no_touch_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !is_mod_w && !is_sat_w && !stat_wr_en) |=> ($stable(stat_sat) && unhandled));

    // R6
    write_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr_en && !stat_wr_sat && !(issue_valid && is_sat_w)) |=> !stat_sat);
endmodule

bind vhadd_unit vhadd_chk u_chk (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .stat_wr_en(stat_wr_en), .stat_wr_sat(stat_wr_sat),
    .res_valid(res_valid), .unhandled(unhandled), .stat_sat(stat_sat)
);

// File: tb/sim_vhadd_unit.sv
module sim_vhadd_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         issue_valid;
    logic [31:0]  instr;
    logic [127:0] opnd_a, opnd_b;
    logic         stat_wr_en, stat_wr_sat;
    logic         res_valid, unhandled, stat_sat;
    logic [127:0] res_data;
    logic [4:0]   res_dst;

    int n_run = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    vhadd_unit u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stat_wr_en(stat_wr_en),
        .stat_wr_sat(stat_wr_sat), .res_valid(res_valid), .res_data(res_data),
        .res_dst(res_dst), .unhandled(unhandled), .stat_sat(stat_sat)
    );

    function automatic logic [31:0] mk(input logic [5:0] p, input logic [4:0] d,
                                       input logic [4:0] sa, input logic [4:0] sb,
                                       input logic [10:0] xo);
        return {p, d, sa, sb, xo};
    endfunction

    function automatic logic [127:0] expect_sum(input logic [127:0] a, input logic [127:0] b,
                                                input bit sat);
        logic [127:0] r;
        for (int i = 0; i < 8; i++) begin
            int s;
            s = int'(a[127 - 16*i -: 16]) + int'(b[127 - 16*i -: 16]);
            if (s > 65535) s = sat ? 65535 : s - 65536;
            r[127 - 16*i -: 16] = s[15:0];
        end
        return r;
    endfunction

    function automatic logic [127:0] splat(input logic [15:0] v);
        return {8{v}};
    endfunction

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_run++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive one cycle, then sample at the following negedge
    task automatic step(input bit iv, input logic [31:0] w, input logic [127:0] a,
                        input logic [127:0] b, input bit we, input bit wv);
        @(negedge clk);
        issue_valid = iv; instr = w; opnd_a = a; opnd_b = b;
        stat_wr_en = we; stat_wr_sat = wv;
        @(negedge clk);
        issue_valid = 1'b0; stat_wr_en = 1'b0; stat_wr_sat = 1'b0;
    endtask

    task automatic clear_flag();
        step(1'b0, 32'h0, '0, '0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        chk("R11 res_valid", {127'b0, res_valid}, 128'd0);
        chk("R11 unhandled", {127'b0, unhandled}, 128'd0);
        chk("R11 res_data", res_data, 128'd0);
        chk("R11 res_dst", {123'b0, res_dst}, 128'd0);
        chk("R11 stat_sat", {127'b0, stat_sat}, 128'd0);
    endtask

    task automatic t_all_ones_plus_one();
        clear_flag();
        step(1'b1, 32'h10000240, splat(16'hFFFF), splat(16'h0001), 1'b0, 1'b0);
        chk("R1 base word accepted", {127'b0, res_valid}, 128'd1);
        chk("R3 ffff+1 clamps", res_data, splat(16'hFFFF));
        chk("R5 flag set", {127'b0, stat_sat}, 128'd1);
    endtask

    task automatic t_exact_max();
        clear_flag();
        step(1'b1, mk(6'd4, 5'd17, 5'd3, 5'd9, 11'd576), splat(16'h8000), splat(16'h7FFF), 1'b0, 1'b0);
        chk("R12 valid without clamp", {127'b0, res_valid}, 128'd1);
        chk("R1 dst index", {123'b0, res_dst}, 128'd17);
        chk("R3 exact ffff", res_data, splat(16'hFFFF));
        chk("R3 no clamp flag", {127'b0, stat_sat}, 128'd0);
    endtask

    task automatic t_one_lane();
        logic [127:0] a, b;
        clear_flag();
        a = 128'h0001_0100_F000_1234_0000_7FFF_0010_ABCD;
        b = 128'h0002_0200_2000_0001_FFFF_0001_0020_0000;
        step(1'b1, mk(6'd4, 5'd31, 5'd1, 5'd2, 11'd576), a, b, 1'b0, 1'b0);
        chk("R2 lane order single clamp", res_data, expect_sum(a, b, 1'b1));
        chk("R2 lane2 value", {112'b0, res_data[95:80]}, 128'hFFFF);
        chk("R5 one lane sets flag", {127'b0, stat_sat}, 128'd1);
        step(1'b1, mk(6'd4, 5'd5, 5'd1, 5'd2, 11'd576), splat(16'h0100), splat(16'h0200), 1'b0, 1'b0);
        chk("R6 later add result", res_data, splat(16'h0300));
        chk("R6 flag sticky", {127'b0, stat_sat}, 128'd1);
    endtask

    task automatic t_modulo();
        logic [127:0] a, b;
        clear_flag();
        a = 128'hFFFF_8000_0001_1234_FFF0_0000_C000_0F0F;
        b = 128'h0001_8000_0002_EDCC_0020_0000_4001_F0F0;
        step(1'b1, mk(6'd4, 5'd8, 5'd0, 5'd0, 11'd64), a, b, 1'b0, 1'b0);
        chk("R4 wrap result", res_data, expect_sum(a, b, 1'b0));
        chk("R7 flag stays 0", {127'b0, stat_sat}, 128'd0);
        step(1'b0, 32'h0, '0, '0, 1'b1, 1'b1);
        step(1'b1, mk(6'd4, 5'd8, 5'd0, 5'd0, 11'd64), a, b, 1'b0, 1'b0);
        chk("R7 flag stays 1", {127'b0, stat_sat}, 128'd1);
    endtask

    task automatic t_unhandled();
        clear_flag();
        step(1'b1, mk(6'd5, 5'd1, 5'd0, 5'd0, 11'd576), splat(16'hFFFF), splat(16'hFFFF), 1'b0, 1'b0);
        chk("R8 bad primary unhandled", {126'b0, unhandled, res_valid}, 128'd2);
        chk("R8 bad primary flag", {127'b0, stat_sat}, 128'd0);
        step(1'b1, mk(6'd4, 5'd1, 5'd0, 5'd0, 11'd577), splat(16'hFFFF), splat(16'hFFFF), 1'b0, 1'b0);
        chk("R8 bad xo unhandled", {126'b0, unhandled, res_valid}, 128'd2);
        chk("R8 bad xo flag", {127'b0, stat_sat}, 128'd0);
    endtask

    task automatic t_same_cycle();
        step(1'b0, 32'h0, '0, '0, 1'b1, 1'b1);
        step(1'b1, 32'h10000240, splat(16'hF000), splat(16'h2000), 1'b1, 1'b0);
        chk("R9 write0 plus clamp", {127'b0, stat_sat}, 128'd1);
        step(1'b1, 32'h10000240, splat(16'h0001), splat(16'h0001), 1'b1, 1'b0);
        chk("R9 write0 no clamp", {127'b0, stat_sat}, 128'd0);
    endtask

    task automatic t_idle();
        step(1'b1, 32'h10000240, splat(16'h0001), splat(16'h0001), 1'b0, 1'b0);
        step(1'b0, 32'h10000240, splat(16'h0001), splat(16'h0001), 1'b0, 1'b0);
        chk("R10 idle no valid", {126'b0, unhandled, res_valid}, 128'd0);
    endtask

    initial begin
        rst = 1'b1; issue_valid = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
        stat_wr_en = 1'b0; stat_wr_sat = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_all_ones_plus_one();
        t_exact_max();
        t_one_lane();
        t_modulo();
        t_unhandled();
        t_same_cycle();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule